// File: doc/BRIEF.md
# Instruction-Decoded Test Data Register Path

This block holds the data-register half of a boundary-scan test port. An external TAP controller supplies the test clock, serial data in, a latched 3-bit instruction, and one strobe each for the capture, shift and update states. From the instruction the block picks one of three serial registers: a 32-bit identification word, a single bypass bit, or a boundary chain of two cells for each line port. The picked register sits between `tdi` and `tdo`. The chain takes parallel snapshots of the core outputs and the pad inputs, and it holds update latches that can take control of the output pins.

Capture and shift happen on the rising test-clock edge. `tdo` is retimed to the falling edge and is enabled only while shifting. Under the external-test instruction, the update latches drive the output pins. Under every other instruction, the core's own output values reach the pins. The sample/preload instruction can still fill the latches ahead of time.

Top module: `jtag_dr_path`

## Requirements
- R1: With instruction 110, capture loads the identification word to the serial path. The word is {revision[3:0] in bits 31..28, part[15:0] in bits 27..12, producer[10:0] in bits 11..1, 1 in bit 0}. It leaves least significant bit first, and a `tdi` bit reappears at `tdo` after exactly 32 shifts.
- R2: With instruction 111, a one-bit register that captures 0 sits between `tdi` and `tdo`. Each `tdi` bit reaches `tdo` one clock period later.
- R3: Instructions 001, 010, 011 and 101 behave exactly like 111.
- R4: With instruction 000 or 100, capture loads the boundary chain. Chain bit 2p takes `core_out[p]` and bit 2p+1 takes `pad_in[p]`, and bit 0 leaves first.
- R5: The boundary chain is 2*NPORT bits long, so a bit shifted in reappears at `tdo` after exactly 2*NPORT shifts.
- R6: Shifting never changes `pin_out`. An update strobe under 000 or 100 copies chain bit 2p into the latch for port p.
- R7: Under 000, `pin_out[p]` equals the update latch of port p. Under any other code, `pin_out` equals `core_out`.
- R8: Latches loaded by an update under 100 do not reach the pins until the instruction becomes 000, and then they drive the pins without a further update.
- R9: `tdo` and `tdo_oe` change only on the falling edge. `tdo_oe` is high only after a falling edge that saw `shift_dr` high.
- R10: Reset (`tap_rst` high at a rising edge) clears the update latches and holds `tdo_oe` low.
- R11: The boundary chain keeps its contents while another instruction captures and shifts its own register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tap_rst | input | 1 | Synchronous active-high reset |
| ir | input | 3 | Latched instruction |
| capture_dr | input | 1 | Capture state strobe |
| shift_dr | input | 1 | Shift state strobe |
| update_dr | input | 1 | Update state strobe |
| tdi | input | 1 | Serial data in |
| core_out | input | NPORT | Core values heading to the output pins |
| pad_in | input | NPORT | Values seen at the input pads |
| pin_out | output | NPORT | Values driven to the output pads |
| tdo | output | 1 | Serial data out, falling-edge timed |
| tdo_oe | output | 1 | Output enable for `tdo` |

## Verification
A capture or update strobe takes effect at the rising edge where it is high, so the bench reads `pin_out` one nanosecond after that edge. A shifted register presents its next bit on `tdo` at the following falling edge, and the bench samples `tdo` one nanosecond after each falling edge, before the next rising edge moves the chain again. For R9, the bench also samples between a rising edge and the next falling edge, to confirm that `tdo` and `tdo_oe` have not yet moved.

// File: rtl/jtag_dr_pkg.sv
`timescale 1ns/1ps
package jtag_dr_pkg;

    localparam int IR_W   = 3;
    localparam int PROD_W = 11;
    localparam int PART_W = 16;
    localparam int REV_W  = 4;
    localparam int ID_W   = 1 + PROD_W + PART_W + REV_W;

    localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
    localparam logic [IR_W-1:0] OP_SAMPLE = 3'b100;
    localparam logic [IR_W-1:0] OP_IDCODE = 3'b110;
    localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;

    typedef enum logic [1:0] {
        PATH_BYP = 2'd0,
        PATH_ID  = 2'd1,
        PATH_BSR = 2'd2
    } dr_path_e;

    typedef struct packed {
        dr_path_e path;
        logic     cells_own_pins;
    } dr_sel_t;

    typedef struct packed {
        logic cap;
        logic sh;
        logic upd;
    } dr_strobe_t;

    function automatic dr_sel_t decode_op(input logic [IR_W-1:0] op);
        dr_sel_t s;
        s.cells_own_pins = 1'b0;
        unique case (op)
            OP_EXTEST: begin
                s.path           = PATH_BSR;
                s.cells_own_pins = 1'b1;
            end
            OP_SAMPLE: s.path = PATH_BSR;
            OP_IDCODE: s.path = PATH_ID;
            default:   s.path = PATH_BYP;
        endcase
        return s;
    endfunction

    function automatic logic [ID_W-1:0] pack_id(
        input logic [PROD_W-1:0] prod,
        input logic [PART_W-1:0] part,
        input logic [REV_W-1:0]  rev
    );
        return {rev, part, prod, 1'b1};
    endfunction

endpackage

// File: rtl/jdr_decode.sv
`timescale 1ns/1ps
module jdr_decode
    import jtag_dr_pkg::*;
(
    input  logic [IR_W-1:0] op,
    input  dr_strobe_t      strobe,
    output dr_sel_t         sel,
    output dr_strobe_t      st_byp,
    output dr_strobe_t      st_id,
    output dr_strobe_t      st_bsr
);
    always_comb begin
        sel    = decode_op(op);
        st_byp = '0;
        st_id  = '0;
        st_bsr = '0;
        unique case (sel.path)
            PATH_ID:  st_id  = strobe;
            PATH_BSR: st_bsr = strobe;
            default:  st_byp = strobe;
        endcase
    end
endmodule

// File: rtl/jdr_bypass_bit.sv
`timescale 1ns/1ps
module jdr_bypass_bit
    import jtag_dr_pkg::*;
(
    input  logic       tck,
    input  logic       tap_rst,
    input  dr_strobe_t st,
    input  logic       tdi,
    output logic       so
);
    always_ff @(posedge tck) begin
        if (tap_rst)     so <= 1'b0;
        else if (st.cap) so <= 1'b0;
        else if (st.sh)  so <= tdi;
    end
endmodule

// File: rtl/jdr_id_reg.sv
`timescale 1ns/1ps
module jdr_id_reg
    import jtag_dr_pkg::*;
#(
    parameter logic [PROD_W-1:0] PRODUCER = '0,
    parameter logic [PART_W-1:0] PART     = '0,
    parameter logic [REV_W-1:0]  REVISION = '0
) (
    input  logic       tck,
    input  logic       tap_rst,
    input  dr_strobe_t st,
    input  logic       tdi,
    output logic       so
);
    localparam logic [ID_W-1:0] ID_WORD = pack_id(PRODUCER, PART, REVISION);

    logic [ID_W-1:0] sr;

    always_ff @(posedge tck) begin
        if (tap_rst)     sr <= ID_WORD;
        else if (st.cap) sr <= ID_WORD;
        else if (st.sh)  sr <= {tdi, sr[ID_W-1:1]};
    end

    assign so = sr[0];
endmodule

// File: rtl/jdr_bsr.sv
`timescale 1ns/1ps
module jdr_bsr
    import jtag_dr_pkg::*;
#(
    parameter int NPORT = 49
) (
    input  logic             tck,
    input  logic             tap_rst,
    input  dr_strobe_t       st,
    input  logic             tdi,
    input  logic [NPORT-1:0] core_out,
    input  logic [NPORT-1:0] pad_in,
    output logic             so,
    output logic [NPORT-1:0] upd_q
);
    localparam int LEN = 2 * NPORT;

    logic [LEN-1:0] cap_vec;
    logic [LEN-1:0] sr;

    for (genvar p = 0; p < NPORT; p++) begin : g_pair
        assign cap_vec[2*p]   = core_out[p];
        assign cap_vec[2*p+1] = pad_in[p];
    end

    always_ff @(posedge tck) begin
        if (tap_rst)     sr <= '0;
        else if (st.cap) sr <= cap_vec;
        else if (st.sh)  sr <= {tdi, sr[LEN-1:1]};
    end

    always_ff @(posedge tck) begin
        if (tap_rst) begin
            upd_q <= '0;
        end else if (st.upd) begin
            for (int p = 0; p < NPORT; p++) upd_q[p] <= sr[2*p];
        end
    end

    assign so = sr[0];
endmodule

// File: rtl/jtag_dr_path.sv
`timescale 1ns/1ps
module jtag_dr_path
    import jtag_dr_pkg::*;
#(
    parameter int                NPORT    = 49,
    parameter logic [PROD_W-1:0] PRODUCER = 11'h2A5,
    parameter logic [PART_W-1:0] PART     = 16'hC3E1,
    parameter logic [REV_W-1:0]  REVISION = 4'h9
) (
    input  logic             tck,
    input  logic             tap_rst,
    input  logic [IR_W-1:0]  ir,
    input  logic             capture_dr,
    input  logic             shift_dr,
    input  logic             update_dr,
    input  logic             tdi,
    input  logic [NPORT-1:0] core_out,
    input  logic [NPORT-1:0] pad_in,
    output logic [NPORT-1:0] pin_out,
    output logic             tdo,
    output logic             tdo_oe
);
    dr_strobe_t       strobe;
    dr_sel_t          sel;
    dr_strobe_t       st_byp, st_id, st_bsr;
    logic             byp_so, id_so, bsr_so, dr_so;
    logic [NPORT-1:0] cell_upd;

    assign strobe = '{cap: capture_dr, sh: shift_dr, upd: update_dr};

    jdr_decode u_dec (
        .op     (ir),
        .strobe (strobe),
        .sel    (sel),
        .st_byp (st_byp),
        .st_id  (st_id),
        .st_bsr (st_bsr)
    );

    jdr_bypass_bit u_byp (
        .tck     (tck),
        .tap_rst (tap_rst),
        .st      (st_byp),
        .tdi     (tdi),
        .so      (byp_so)
    );

    jdr_id_reg #(
        .PRODUCER (PRODUCER),
        .PART     (PART),
        .REVISION (REVISION)
    ) u_id (
        .tck     (tck),
        .tap_rst (tap_rst),
        .st      (st_id),
        .tdi     (tdi),
        .so      (id_so)
    );

    jdr_bsr #(.NPORT(NPORT)) u_bsr (
        .tck      (tck),
        .tap_rst  (tap_rst),
        .st       (st_bsr),
        .tdi      (tdi),
        .core_out (core_out),
        .pad_in   (pad_in),
        .so       (bsr_so),
        .upd_q    (cell_upd)
    );

    always_comb begin
        unique case (sel.path)
            PATH_ID:  dr_so = id_so;
            PATH_BSR: dr_so = bsr_so;
            default:  dr_so = byp_so;
        endcase
    end

    always_ff @(negedge tck) begin
        if (tap_rst) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo_oe <= shift_dr;
            if (shift_dr) tdo <= dr_so;
        end
    end

    assign pin_out = sel.cells_own_pins ? cell_upd : core_out;
endmodule

// File: rtl/jdr_checker.sv
`timescale 1ns/1ps
module jdr_checker #(
    parameter int NPORT = 49
) (
    input logic             tck,
    input logic             tap_rst,
    input logic [2:0]       ir,
    input logic             capture_dr,
    input logic             shift_dr,
    input logic             update_dr,
    input logic [NPORT-1:0] core_out,
    input logic [NPORT-1:0] pin_out,
    input logic             tdo_oe,
    input logic [NPORT-1:0] upd_q,
    input logic             id_so,
    input logic             byp_so
);
    logic byp_code;
    assign byp_code = (ir != 3'b000) && (ir != 3'b100) && (ir != 3'b110);

    AST_ID_CAPTURE_LSB: assert property (@(posedge tck) disable iff (tap_rst)
        (capture_dr && ir == 3'b110) |=> id_so);                          // R1

    AST_BYP_CAPTURE_ZERO: assert property (@(posedge tck) disable iff (tap_rst)
        (capture_dr && byp_code) |=> !byp_so);                            // R3

    AST_FUNC_PINS: assert property (@(posedge tck) disable iff (tap_rst)
        (ir != 3'b000) |-> (pin_out == core_out));                        // R7

    AST_EXTEST_PINS_HOLD: assert property (@(posedge tck) disable iff (tap_rst)
        (ir == 3'b000 && !update_dr) |=> (ir != 3'b000 || $stable(pin_out))); // R6

    AST_LATCH_ONLY_ON_UPDATE: assert property (@(posedge tck) disable iff (tap_rst)
        !update_dr |=> $stable(upd_q));                                   // R6

    AST_OE_ONLY_IN_SHIFT: assert property (@(posedge tck) disable iff (tap_rst)
        tdo_oe |-> shift_dr);                                             // R9
endmodule

bind jtag_dr_path jdr_checker #(.NPORT(NPORT)) u_chk (
    .tck        (tck),
    .tap_rst    (tap_rst),
    .ir         (ir),
    .capture_dr (capture_dr),
    .shift_dr   (shift_dr),
    .update_dr  (update_dr),
    .core_out   (core_out),
    .pin_out    (pin_out),
    .tdo_oe     (tdo_oe),
    .upd_q      (cell_upd),
    .id_so      (id_so),
    .byp_so     (byp_so)
);

// File: tb/jtag_dr_path_test.sv
`timescale 1ns/1ps
module jtag_dr_path_test;
    localparam int NPORT = 49;
    localparam int LEN   = 2 * NPORT;
    localparam logic [10:0] PROD = 11'h2A5;
    localparam logic [15:0] PRT  = 16'hC3E1;
    localparam logic [3:0]  REV  = 4'h9;
    localparam logic [31:0] EXP_ID = {REV, PRT, PROD, 1'b1};

    // {instruction, kind (0 bypass, 1 id, 2 chain), cells own pins}
    localparam logic [5:0] VEC [8] = '{
        {3'b000, 2'd2, 1'b1},
        {3'b001, 2'd0, 1'b0},
        {3'b010, 2'd0, 1'b0},
        {3'b011, 2'd0, 1'b0},
        {3'b100, 2'd2, 1'b0},
        {3'b101, 2'd0, 1'b0},
        {3'b110, 2'd1, 1'b0},
        {3'b111, 2'd0, 1'b0}
    };

    logic             tck = 1'b0;
    logic             tap_rst = 1'b1;
    logic [2:0]       ir = 3'b111;
    logic             capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, tdi = 1'b0;
    logic [NPORT-1:0] core_out = 49'h1_5A5A_C3C3_0F0F;
    logic [NPORT-1:0] pad_in   = 49'h0_9E37_79B9_7F4A;
    logic [NPORT-1:0] pin_out;
    logic             tdo, tdo_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #5 tck = ~tck;

    jtag_dr_path #(.NPORT(NPORT), .PRODUCER(PROD), .PART(PRT), .REVISION(REV)) uut (
        .tck(tck), .tap_rst(tap_rst), .ir(ir), .capture_dr(capture_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi),
        .core_out(core_out), .pad_in(pad_in), .pin_out(pin_out),
        .tdo(tdo), .tdo_oe(tdo_oe)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge tck);
        #1;
    endtask

    task automatic do_capture();
        capture_dr = 1'b1;
        tick();
        capture_dr = 1'b0;
    endtask

    task automatic do_update();
        update_dr = 1'b1;
        tick();
        update_dr = 1'b0;
    endtask

    task automatic shift_n(input int n, input logic [127:0] din, output logic [127:0] dout);
        dout = '0;
        shift_dr = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge tck);
            #1;
            dout[k] = tdo;
            tdi = din[k];
            @(posedge tck);
            #1;
        end
        shift_dr = 1'b0;
        tdi = 1'b0;
    endtask

    function automatic logic [LEN-1:0] cap_model();
        logic [LEN-1:0] v;
        for (int p = 0; p < NPORT; p++) begin
            v[2*p]   = core_out[p];
            v[2*p+1] = pad_in[p];
        end
        return v;
    endfunction

    function automatic logic [NPORT-1:0] evens(input logic [LEN-1:0] v);
        logic [NPORT-1:0] e;
        for (int p = 0; p < NPORT; p++) e[p] = v[2*p];
        return e;
    endfunction

    initial begin
        repeat (150000) @(posedge tck);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [127:0] got, exp, pat;
        logic [LEN-1:0] pa, pc;
        string tag;

        // reset state
        repeat (3) tick();
        chk("R10 oe low in reset", tdo_oe, 0);
        chk("R7 pins functional", pin_out, core_out);
        ir = 3'b000;
        #1;
        chk("R10 latches cleared", pin_out, 0);
        tap_rst = 1'b0;
        ir = 3'b111;
        tick();

        // table walk over all eight codes
        pat = 128'h0000_0000_0000_00A7_35C9_1E6B_D248_F00D;
        for (int v = 0; v < 8; v++) begin
            ir = VEC[v][5:3];
            tick();
            do_capture();
            shift_n(40, pat, got);
            exp = '0;
            case (VEC[v][2:1])
                2'd1: begin
                    exp[31:0]  = EXP_ID;
                    exp[39:32] = pat[7:0];
                    tag = "R1";
                end
                2'd2: begin
                    exp[39:0] = cap_model() & {LEN{1'b1}};
                    tag = "R4";
                end
                default: begin
                    exp[0]    = 1'b0;
                    exp[39:1] = pat[38:0];
                    tag = (VEC[v][5:3] == 3'b111) ? "R2" : "R3";
                end
            endcase
            chk(tag, got[39:0], exp[39:0]);
            chk("R7 pins by code", pin_out, VEC[v][0] ? {NPORT{1'b0}} : core_out);
        end

        // falling-edge timing of tdo and tdo_oe
        ir = 3'b111;
        tick();
        do_capture();
        tdi = 1'b1;
        shift_dr = 1'b1;
        #1;
        chk("R9 oe waits for falling edge", tdo_oe, 0);
        @(negedge tck); #1;
        chk("R9 oe after falling edge", tdo_oe, 1);
        chk("R9 first bit", tdo, 0);
        @(posedge tck); #1;
        chk("R9 tdo holds after rising edge", tdo, 0);
        @(negedge tck); #1;
        chk("R9 tdo moves on falling edge", tdo, 1);
        @(posedge tck); #1;
        shift_dr = 1'b0;
        tdi = 1'b0;
        @(negedge tck); #1;
        chk("R9 oe drops", tdo_oe, 0);
        tick();

        // full chain under external test
        pa = 98'h2_F0E1_D2C3_B4A5_9687_7869_5A4B;
        ir = 3'b000;
        tick();
        do_capture();
        shift_n(LEN, 128'(pa), got);
        chk("R4 full capture", got[LEN-1:0], cap_model());
        chk("R6 shift leaves pins", pin_out, 0);
        do_update();
        chk("R6 update drives pins", pin_out, evens(pa));
        shift_n(LEN, 128'h0, got);
        chk("R5 chain length", got[LEN-1:0], pa);
        chk("R6 pins hold while shifting", pin_out, evens(pa));

        // preload under sample
        pc = 98'h1_0123_4567_89AB_CDEF_FEDC_BA98;
        ir = 3'b100;
        tick();
        chk("R7 sample keeps core path", pin_out, core_out);
        shift_n(LEN, 128'(pc), got);
        do_update();
        chk("R8 preload hidden", pin_out, core_out);
        ir = 3'b000;
        #1;
        chk("R8 preload on pins", pin_out, evens(pc));

        // identification with chain retention
        ir = 3'b110;
        tick();
        do_capture();
        shift_n(40, pat, got);
        chk("R1 id then tdi", got[39:0], {pat[7:0], EXP_ID});
        ir = 3'b100;
        tick();
        shift_n(LEN, 128'h0, got);
        chk("R11 chain retained", got[LEN-1:0], pc);

        // reset under external test
        ir = 3'b000;
        tick();
        chk("R8 pins before reset", pin_out, evens(pc));
        tap_rst = 1'b1;
        tick();
        tap_rst = 1'b0;
        chk("R10 reset clears latches", pin_out, 0);
        chk("R10 oe after reset", tdo_oe, 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule